// File: doc/BRIEF.md
# Windowed Register File

This block holds the integer registers of a processor whose procedure calls rotate a window over a larger physical store. Software always sees 32 logical registers, numbered with 5 bits, through two combinational read ports and one write port. Behind them, a current window pointer picks which slice of physical storage the upper 24 logical numbers reach. Register 0 is hardwired to zero. Registers 1 to 7 are shared by every window. Each window owns eight locals. The eight input registers of a window are the same storage as the eight output registers of the window below it, so a caller passes arguments just by writing its outputs.

A save request opens the next window on procedure entry and a restore request goes back to the caller. A live-window count tracks how many windows hold state. When a save would reuse storage still in use, the block raises an overflow pulse and does not move. When a restore would drop below the root window, it raises an underflow pulse. Logic outside the block uses these pulses to spill or fill windows through a trap. Storage is 8 global slots plus 16 slots per window, with the window count as a parameter.

Top module: `windowedRegFile`

## Requirements
- R1: Logical register 0 always reads as zero on both read ports, and a write to it changes nothing.
- R2: Logical registers 1 to 7 reach the same storage in every window, so a value written in one window reads back unchanged in any other.
- R3: After a save, logical inputs 24+k of the new window read what logical outputs 8+k held in the old window. After the matching restore, outputs 8+k of the caller read what the callee wrote to inputs 24+k.
- R4: Logical registers 16 to 23 are private to a window: a window opened by a save reads zero there until written, and the caller's locals are intact after the restore.
- R5: Reset sets the window pointer to 0, the live count to 1, both flags to 0 and every register to zero.
- R6: An accepted save increments both the window pointer and the live count. An accepted restore decrements both. The new values are visible after the clock edge that takes the request.
- R7: A save while the live count equals NWIN-1 raises `overflow` for exactly one cycle after that edge, and leaves the pointer and the count unchanged.
- R8: A restore while the live count equals 1 raises `underflow` for exactly one cycle after that edge, and leaves the pointer and the count unchanged.
- R9: A read of the register being written in the same cycle returns the old value. The new value appears after the clock edge, with no forwarding.
- R10: A write issued in the same cycle as a save is decoded through the window in force before the save.
- R11: A save and a restore requested in the same cycle are both ignored: no pointer move, no count change, no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Logical register number, read port A |
| rdDataA | output | 32 | Read data, port A (combinational) |
| rdAddrB | input | 5 | Logical register number, read port B |
| rdDataB | output | 32 | Read data, port B (combinational) |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical register number to write |
| wrData | input | 32 | Write data |
| saveReq | input | 1 | Open a new window |
| restoreReq | input | 1 | Return to the caller's window |
| winPtr | output | 3 | Current window pointer |
| liveCount | output | 4 | Number of live windows |
| overflow | output | 1 | One-cycle pulse: save refused |
| underflow | output | 1 | One-cycle pulse: restore refused |

## Verification
The collision that matters is a register write and a window move in the same cycle. The write must land through the old mapping while the pointer advances. The bench provokes it by writing output register 9 in the very cycle that save is asserted. It then reads input register 25 in the new window and expects the written value. A second collision, save and restore together, is driven in one cycle and judged by an unmoved pointer and count with both flags low. A read of a register in the cycle it is being written is also compared against the previous contents.

// File: rtl/wrfPkg.sv
package wrfPkg;
  // strobes from window control to the storage datapath
  typedef struct packed {
    logic       wrGo;   // qualified write, never to register 0
    logic [4:0] wrReg;  // logical target of the write
  } wrfStrobe_t;

  localparam int LOGICAL_REGS = 32;
  localparam int GLOBAL_SLOTS = 8;
  localparam int SLOTS_PER_WIN = 16;
endpackage

// File: rtl/wrfWindowCtl.sv
module wrfWindowCtl
  import wrfPkg::*;
#(
  parameter int NWIN = 8,
  localparam int WW = $clog2(NWIN),
  localparam int CW = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          saveReq,
  input  logic          restoreReq,
  input  logic          wrEn,
  input  logic [4:0]    wrAddr,
  output logic [WW-1:0] curWin,
  output logic [CW-1:0] liveCnt,
  output logic          ovfPulse,
  output logic          unfPulse,
  output wrfStrobe_t    strb
);
  localparam logic [CW-1:0] MAX_LIVE = CW'(NWIN - 1);
  localparam logic [WW-1:0] TOP_WIN  = WW'(NWIN - 1);

  logic saveOnly, restoreOnly, saveOk, restoreOk;

  assign saveOnly    = saveReq && !restoreReq;
  assign restoreOnly = restoreReq && !saveReq;
  assign saveOk      = saveOnly && (liveCnt != MAX_LIVE);
  assign restoreOk   = restoreOnly && (liveCnt != CW'(1));

  assign strb.wrGo  = wrEn && (wrAddr != 5'd0);
  assign strb.wrReg = wrAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWin   <= '0;
      liveCnt  <= CW'(1);
      ovfPulse <= 1'b0;
      unfPulse <= 1'b0;
    end else begin
      ovfPulse <= saveOnly && !saveOk;
      unfPulse <= restoreOnly && !restoreOk;
      if (saveOk) begin
        curWin  <= (curWin == TOP_WIN) ? '0 : curWin + 1'b1;
        liveCnt <= liveCnt + 1'b1;
      end else if (restoreOk) begin
        curWin  <= (curWin == '0) ? TOP_WIN : curWin - 1'b1;
        liveCnt <= liveCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrfStore.sv
module wrfStore
  import wrfPkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 32,
  localparam int WW = $clog2(NWIN),
  localparam int PHYS = GLOBAL_SLOTS + SLOTS_PER_WIN * NWIN,
  localparam int PW = $clog2(PHYS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [WW-1:0] curWin,
  input  wrfStrobe_t    strb,
  input  logic [DW-1:0] wrData,
  input  logic [4:0]    rdAddrA,
  input  logic [4:0]    rdAddrB,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB
);
  logic [DW-1:0] slots [PHYS];

  // logical number plus window -> physical slot
  function automatic logic [PW-1:0] mapReg(input logic [4:0] r, input logic [WW-1:0] w);
    logic [WW-1:0] below;
    logic [PW-1:0] winBase, belowBase;
    below     = (w == '0) ? WW'(NWIN - 1) : w - 1'b1;
    winBase   = PW'(GLOBAL_SLOTS) + PW'(w) * PW'(SLOTS_PER_WIN);
    belowBase = PW'(GLOBAL_SLOTS) + PW'(below) * PW'(SLOTS_PER_WIN);
    case (r[4:3])
      2'b00:   return PW'(r[2:0]);
      2'b01:   return winBase + PW'(r[2:0]);
      2'b10:   return winBase + PW'(8) + PW'(r[2:0]);
      default: return belowBase + PW'(r[2:0]);
    endcase
  endfunction

  logic [PW-1:0] wrSlot;
  assign wrSlot = mapReg(strb.wrReg, curWin);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS; i++) slots[i] <= '0;
    end else if (strb.wrGo) begin
      slots[wrSlot] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == 5'd0) ? '0 : slots[mapReg(rdAddrA, curWin)];
  assign rdDataB = (rdAddrB == 5'd0) ? '0 : slots[mapReg(rdAddrB, curWin)];
endmodule

// File: rtl/windowedRegFile.sv
module windowedRegFile
  import wrfPkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW = 32,
  localparam int WW = $clog2(NWIN),
  localparam int CW = $clog2(NWIN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [4:0]    rdAddrA,
  output logic [DW-1:0] rdDataA,
  input  logic [4:0]    rdAddrB,
  output logic [DW-1:0] rdDataB,
  input  logic          wrEn,
  input  logic [4:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          saveReq,
  input  logic          restoreReq,
  output logic [WW-1:0] winPtr,
  output logic [CW-1:0] liveCount,
  output logic          overflow,
  output logic          underflow
);
  wrfStrobe_t strb;

  wrfWindowCtl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .wrEn(wrEn), .wrAddr(wrAddr), .curWin(winPtr), .liveCnt(liveCount),
    .ovfPulse(overflow), .unfPulse(underflow), .strb(strb)
  );

  wrfStore #(.NWIN(NWIN), .DW(DW)) u_store (
    .clk(clk), .rstN(rstN), .curWin(winPtr), .strb(strb), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB)
  );
endmodule

// File: rtl/wrfChecker.sv
module wrfChecker #(
  parameter int NWIN = 8,
  parameter int DW = 32,
  localparam int WW = $clog2(NWIN),
  localparam int CW = $clog2(NWIN + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [4:0]    rdAddrA,
  input logic [DW-1:0] rdDataA,
  input logic [4:0]    rdAddrB,
  input logic [DW-1:0] rdDataB,
  input logic          saveReq,
  input logic          restoreReq,
  input logic [WW-1:0] winPtr,
  input logic [CW-1:0] liveCount,
  input logic          overflow,
  input logic          underflow
);
  AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrA == 5'd0 |-> rdDataA == '0); // R1
  AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrB == 5'd0 |-> rdDataB == '0); // R1
  AST_LIVE_BOUNDS: assert property (@(posedge clk) disable iff (!rstN)
    liveCount >= CW'(1) && liveCount <= CW'(NWIN - 1)); // R6
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    saveReq && !restoreReq && liveCount != CW'(NWIN - 1) |=> liveCount == $past(liveCount) + 1'b1); // R6
  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    saveReq && !restoreReq && liveCount == CW'(NWIN - 1) |=> overflow && $stable(winPtr) && $stable(liveCount)); // R7
  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq && !saveReq && liveCount == CW'(1) |=> underflow && $stable(winPtr) && $stable(liveCount)); // R8
  AST_FLAGS_APART: assert property (@(posedge clk) disable iff (!rstN)
    !(overflow && underflow)); // R7
  AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    saveReq && restoreReq |=> $stable(winPtr) && !overflow && !underflow); // R11
endmodule

bind windowedRegFile wrfChecker #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .rdAddrB(rdAddrB), .rdDataB(rdDataB), .saveReq(saveReq),
  .restoreReq(restoreReq), .winPtr(winPtr), .liveCount(liveCount),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/windowedRegFile_bench.sv
module windowedRegFile_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, saveReq = 1'b0, restoreReq = 1'b0;
  logic [2:0]  winPtr;
  logic [3:0]  liveCount;
  logic        overflow, underflow;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  windowedRegFile u_windowedRegFile (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .saveReq(saveReq), .restoreReq(restoreReq),
    .winPtr(winPtr), .liveCount(liveCount), .overflow(overflow), .underflow(underflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readA(input logic [4:0] r, output logic [31:0] v);
    rdAddrA = r; #1; v = rdDataA;
  endtask

  task automatic readB(input logic [4:0] r, output logic [31:0] v);
    rdAddrB = r; #1; v = rdDataB;
  endtask

  task automatic writeReg(input logic [4:0] r, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = r; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // one cycle of save/restore request; flags are sampled at the following negedge
  task automatic step(input logic s, input logic rs, output logic ovf, output logic unf);
    @(negedge clk); saveReq = s; restoreReq = rs;
    @(negedge clk); ovf = overflow; unf = underflow; saveReq = 1'b0; restoreReq = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R5 winPtr", 32'(winPtr), 0);
    check("R5 liveCount", 32'(liveCount), 1);
    check("R5 flags", {30'd0, overflow, underflow}, 0);
    readA(5'd9, v); check("R5 out reg zero", v, 0);
    readB(5'd20, v); check("R5 local zero", v, 0);
  endtask

  task automatic testZero();
    logic [31:0] v;
    writeReg(5'd0, 32'hDEAD_BEEF);
    readA(5'd0, v); check("R1 port A", v, 0);
    readB(5'd0, v); check("R1 port B", v, 0);
  endtask

  task automatic testWindows();
    logic [31:0] v;
    logic o, u;
    writeReg(5'd3, 32'h0000_0333);
    writeReg(5'd9, 32'h0000_0909);
    writeReg(5'd17, 32'h0000_1717);
    step(1'b1, 1'b0, o, u);
    check("R6 save ptr", 32'(winPtr), 1);
    check("R6 save live", 32'(liveCount), 2);
    readA(5'd3, v); check("R2 global seen after save", v, 32'h333);
    readB(5'd25, v); check("R3 input aliases caller output", v, 32'h909);
    readA(5'd17, v); check("R4 fresh local", v, 0);
    writeReg(5'd17, 32'h0000_AAAA);
    writeReg(5'd26, 32'h0000_2626);
    writeReg(5'd5, 32'h0000_0555);
    step(1'b0, 1'b1, o, u);
    check("R6 restore ptr", 32'(winPtr), 0);
    check("R6 restore live", 32'(liveCount), 1);
    readA(5'd10, v); check("R3 caller output sees callee input", v, 32'h2626);
    readB(5'd17, v); check("R4 caller local intact", v, 32'h1717);
    readA(5'd5, v); check("R2 global from callee", v, 32'h555);
  endtask

  task automatic testSameCycleRead();
    logic [31:0] v;
    writeReg(5'd12, 32'h1111_1111);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd12; wrData = 32'h2222_2222;
    readA(5'd12, v); check("R9 old value during write", v, 32'h1111_1111);
    @(negedge clk); wrEn = 1'b0;
    readA(5'd12, v); check("R9 new value after edge", v, 32'h2222_2222);
  endtask

  task automatic testWriteWithSave();
    logic [31:0] v;
    logic o, u;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'hCAFE_0009; saveReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; saveReq = 1'b0;
    check("R10 ptr moved", 32'(winPtr), 1);
    readA(5'd25, v); check("R10 write used old window", v, 32'hCAFE_0009);
    readB(5'd9, v); check("R10 new window outputs untouched", v, 0);
    step(1'b0, 1'b1, o, u);
    check("R10 back to window 0", 32'(winPtr), 0);
  endtask

  task automatic testBoth();
    logic o, u;
    step(1'b1, 1'b0, o, u);
    step(1'b1, 1'b1, o, u);
    check("R11 ptr unchanged", 32'(winPtr), 1);
    check("R11 live unchanged", 32'(liveCount), 2);
    check("R11 no flags", {30'd0, o, u}, 0);
    step(1'b0, 1'b1, o, u);
  endtask

  task automatic testLimits();
    logic [31:0] v;
    logic o, u;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, o, u);
      check("R7 no early overflow", 32'(o), 0);
    end
    check("R6 ptr at top", 32'(winPtr), 6);
    check("R6 live at top", 32'(liveCount), 7);
    step(1'b1, 1'b0, o, u);
    check("R7 overflow raised", 32'(o), 1);
    check("R7 ptr held", 32'(winPtr), 6);
    check("R7 live held", 32'(liveCount), 7);
    @(negedge clk);
    check("R7 overflow one cycle", 32'(overflow), 0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, o, u);
      check("R8 no early underflow", 32'(u), 0);
    end
    check("R8 ptr at root", 32'(winPtr), 0);
    step(1'b0, 1'b1, o, u);
    check("R8 underflow raised", 32'(u), 1);
    check("R8 ptr held", 32'(winPtr), 0);
    check("R8 live held", 32'(liveCount), 1);
    @(negedge clk);
    check("R8 underflow one cycle", 32'(underflow), 0);
    readA(5'd17, v); check("R4 root local after round trip", v, 32'h1717);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZero();
    testWindows();
    testSameCycleRead();
    testWriteWithSave();
    testBoth();
    testLimits();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule